// File: doc/BRIEF.md
# Lockable Clock-Buffer Control Register File

This block holds the byte-wide control and status registers of an eight-output clock fan-out device. A simple register bus reaches it: an address, write data, a write strobe, a read strobe and registered read data. The control registers hold these fields:

- per-output enables
- side-band disable masks
- slew-rate selections and slew-rate option codes
- output amplitude
- input coupling and termination settings
- a block-read byte count

The enables are also presented decoded, one bit per output. All other control bytes are presented on a flat bus for the analog side.

Two independent write locks guard the control registers. One of them, once set, stays set until the block is reset. The other toggles each time a one is written to it. While either lock is set, writes to the control registers are dropped. The lock register and the lock/event register stay writable.

A sticky loss-of-signal flag records any cycle in which the active-low loss input is low. Software clears it by writing a one to it. A live copy of the loss input can be read back. Identification bytes are fixed and read-only.

Top module: `clkbuf_regfile`

## Requirements
- R1: After reset, the control bytes read as follows:
  - 0x00 = 0xEE, 0x01 = 0x24, 0x04 = 0x10, 0x07 = 0x07
  - 0x08 = 0x00, 0x09 = 0x00, 0x11 = 0x60
  - 0x12 = 0x08 OR the live loss bit
  - 0x14 = 0xEE, 0x15 = 0x24
  - 0x5B = 0x60, 0x5C = 0xFA, 0x62 = 0x00
  - read data, both locks and the loss flag are 0.
- R2: When unlocked, a write to a control byte stores the write data ANDed with that byte's writable mask. The masks are:
  - 0xEE for 0x00, 0x08 and 0x14
  - 0x24 for 0x01, 0x09 and 0x15
  - 0x10 for 0x04, 0x1F for 0x07, 0xF0 for 0x11, 0xC8 for 0x12
  - 0xFF for 0x5B, 0x5C and 0x62.
  Reserved bits read 0.
- R3: Read data appears on the cycle after a read strobe and holds until the next read strobe. It reflects the state before any write in the same cycle. Reads change no state.
- R4: Writing 1 to bit 0 of 0x26 sets the permanent lock. No write clears it, and it reads back in bit 0 of 0x26.
- R5: Writing 1 to bit 0 of 0x27 toggles the clearable lock: it sets the lock when clear and clears it when set. Writing 0 to that bit leaves the lock unchanged. The lock reads back in bit 0 of 0x27.
- R6: While either lock is set, writes to every offset other than 0x26 and 0x27 have no effect. Writes to 0x26 and 0x27 still take effect.
- R7: The loss flag (bit 1 of 0x27) is set on the cycle after the loss input is low. Writing 1 to it clears it. If a clear and a low loss input occur in the same cycle, the flag stays set.
- R8: Bit 0 of 0x12 returns the loss input as sampled in the read-strobe cycle, where 0 means loss is present.
- R9: 0x05 reads 0x0A and 0x06 reads 0x08. Writes to them have no effect.
- R10: Unmapped offsets read 0x00. Writes to them change nothing that can be read.
- R11: outEn[k] is the enable for output k:
  - outputs 2 to 7 come from bits 7, 6, 5, 3, 2, 1 of 0x00
  - outputs 0 and 1 come from bits 5 and 2 of 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the only way to clear the permanent lock |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Register offset |
| wrData | input | 8 | Write data |
| lossN | input | 1 | Loss detector, active low, synchronous to clk |
| rdData | output | 8 | Registered read data |
| outEn | output | 8 | Decoded per-output enables |
| cfgRegs | output | 104 | All 13 control bytes, map entry i in bits 8i+7:8i |
| lossEvent | output | 1 | Sticky loss flag |
| writeLocked | output | 1 | Either lock is set |

## Verification
The properties take for granted that the loss input is already synchronous to the clock. They also assume that each bus cycle carries at most one write, to a single offset. The stimulus changes every input only on the falling edge, and it drives one address per cycle. During the random phase it keeps the loss input mostly high, so that the sticky flag is cleared as well as set. It keeps random writes away from the permanent lock, so that most of the run exercises unlocked writes. That lock is covered separately by directed steps at the end.

// File: rtl/clkbuf_regs_pkg.sv
`timescale 1ns/1ps
package clkbuf_regs_pkg;
  localparam int DW = 8;
  localparam int AW = 8;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] wmask;
    logic [DW-1:0] rstVal;
  } ctrlDesc_t;

  localparam int NUM_CTRL = 13;
  // entry index = position in cfgRegs
  localparam ctrlDesc_t CTRL_MAP [NUM_CTRL] = '{
    '{8'h00, 8'hEE, 8'hEE},  // enables, outputs 2..7
    '{8'h01, 8'h24, 8'h24},  // enables, outputs 0..1
    '{8'h04, 8'h10, 8'h10},  // automatic disable on loss
    '{8'h07, 8'h1F, 8'h07},  // block-read byte count
    '{8'h08, 8'hEE, 8'h00},  // side-band masks, outputs 2..7
    '{8'h09, 8'h24, 8'h00},  // side-band masks, outputs 0..1
    '{8'h11, 8'hF0, 8'h60},  // amplitude code
    '{8'h12, 8'hC8, 8'h08},  // input coupling, termination, keep-config
    '{8'h14, 8'hEE, 8'hEE},  // slew select high bit, outputs 2..7
    '{8'h15, 8'h24, 8'h24},  // slew select high bit, outputs 0..1
    '{8'h5B, 8'hFF, 8'h60},  // slew option codes A/B
    '{8'h5C, 8'hFF, 8'hFA},  // slew option codes C/D
    '{8'h62, 8'hFF, 8'h00}   // slew select low bits
  };
  localparam int IDX_EN_HI = 0;
  localparam int IDX_EN_LO = 1;

  localparam logic [AW-1:0] ADDR_PERM_LOCK = 8'h26;
  localparam logic [AW-1:0] ADDR_LOCK_EVT  = 8'h27;
  localparam logic [AW-1:0] ADDR_IN_CFG    = 8'h12;
  localparam logic [AW-1:0] ADDR_ID_LO     = 8'h05;
  localparam logic [AW-1:0] ADDR_ID_HI     = 8'h06;
  localparam logic [DW-1:0] ID_LO_VAL      = 8'h0A;
  localparam logic [DW-1:0] ID_HI_VAL      = 8'h08;

  typedef struct packed {
    logic [NUM_CTRL-1:0] regWe;
    logic                permSet;
    logic                softToggle;
    logic                lossClr;
    logic                rdStb;
    logic [DW-1:0]       wData;
    logic [AW-1:0]       rAddr;
  } regStrobe_t;
endpackage

// File: rtl/clkbuf_reg_ctrl.sv
`timescale 1ns/1ps
module clkbuf_reg_ctrl
  import clkbuf_regs_pkg::*;
(
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic          permLock,
  input  logic          softLock,
  output regStrobe_t    strb
);
  logic locked;

  always_comb begin
    locked = permLock | softLock;
    strb = '0;
    strb.wData = wrData;
    strb.rAddr = addr;
    strb.rdStb = rdEn;
    if (wrEn) begin
      if (addr == ADDR_PERM_LOCK) begin
        strb.permSet = wrData[0];
      end else if (addr == ADDR_LOCK_EVT) begin
        strb.softToggle = wrData[0];
        strb.lossClr    = wrData[1];
      end else if (!locked) begin
        for (int i = 0; i < NUM_CTRL; i++)
          strb.regWe[i] = (addr == CTRL_MAP[i].addr);
      end
    end
  end
endmodule

// File: rtl/clkbuf_reg_dp.sv
`timescale 1ns/1ps
module clkbuf_reg_dp
  import clkbuf_regs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strb,
  input  logic                   lossN,
  output logic                   permLock,
  output logic                   softLock,
  output logic                   lossEvt,
  output logic [DW-1:0]          rdData,
  output logic [NUM_CTRL*DW-1:0] ctrlFlat
);
  logic [DW-1:0] rdNext;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : gCtrl
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)               q <= CTRL_MAP[g].rstVal;
      else if (strb.regWe[g])  q <= strb.wData & CTRL_MAP[g].wmask;
    end
    assign ctrlFlat[g*DW +: DW] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      permLock <= 1'b0;
      softLock <= 1'b0;
      lossEvt  <= 1'b0;
    end else begin
      if (strb.permSet)    permLock <= 1'b1;
      if (strb.softToggle) softLock <= !softLock;
      lossEvt <= !lossN | (lossEvt & !strb.lossClr);
    end
  end

  always_comb begin
    rdNext = '0;
    case (strb.rAddr)
      ADDR_ID_LO:     rdNext = ID_LO_VAL;
      ADDR_ID_HI:     rdNext = ID_HI_VAL;
      ADDR_PERM_LOCK: rdNext = {{(DW-1){1'b0}}, permLock};
      ADDR_LOCK_EVT:  rdNext = {{(DW-2){1'b0}}, lossEvt, softLock};
      default: begin
        for (int i = 0; i < NUM_CTRL; i++)
          if (strb.rAddr == CTRL_MAP[i].addr) rdNext = ctrlFlat[i*DW +: DW];
        if (strb.rAddr == ADDR_IN_CFG) rdNext[0] = lossN;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdData <= '0;
    else if (strb.rdStb) rdData <= rdNext;
  end

  a_r4_perm_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    permLock |=> permLock);
  a_r5_soft_lock_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.softToggle |=> $stable(softLock));
  a_r6_locked_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (permLock || softLock) |=> $stable(ctrlFlat));
  a_r7_loss_sets: assert property (@(posedge clk) disable iff (!rstN)
    !lossN |=> lossEvt);
  a_r7_loss_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lossEvt && !strb.lossClr) |=> lossEvt);
  a_r3_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStb |=> $stable(rdData));
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.regWe));
endmodule

// File: rtl/clkbuf_regfile.sv
`timescale 1ns/1ps
module clkbuf_regfile
  import clkbuf_regs_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wrData,
  input  logic                   lossN,
  output logic [DW-1:0]          rdData,
  output logic [7:0]             outEn,
  output logic [NUM_CTRL*DW-1:0] cfgRegs,
  output logic                   lossEvent,
  output logic                   writeLocked
);
  regStrobe_t    strb;
  logic          permLock;
  logic          softLock;
  logic [DW-1:0] enHi;
  logic [DW-1:0] enLo;

  clkbuf_reg_ctrl uCtrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .permLock(permLock), .softLock(softLock), .strb(strb)
  );

  clkbuf_reg_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .lossN(lossN),
    .permLock(permLock), .softLock(softLock), .lossEvt(lossEvent),
    .rdData(rdData), .ctrlFlat(cfgRegs)
  );

  assign enHi = cfgRegs[IDX_EN_HI*DW +: DW];
  assign enLo = cfgRegs[IDX_EN_LO*DW +: DW];
  // R11: output k enable
  assign outEn = {enHi[1], enHi[2], enHi[3], enHi[5], enHi[6], enHi[7],
                  enLo[2], enLo[5]};
  assign writeLocked = permLock | softLock;
endmodule

// File: tb/clkbuf_regfile_test.sv
`timescale 1ns/1ps
module clkbuf_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN, wrEn, rdEn, lossN;
  logic [7:0]  addr, wrData, rdData, outEn;
  logic [103:0] cfgRegs;
  logic        lossEvent, writeLocked;

  int nChk = 0;
  int nFail = 0;
  logic [7:0] mReg [256];
  bit mPerm, mSoft, mLoss;
  logic [7:0] lastRd;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkbuf_regfile uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .lossN(lossN), .rdData(rdData), .outEn(outEn),
    .cfgRegs(cfgRegs), .lossEvent(lossEvent), .writeLocked(writeLocked)
  );

  function automatic logic [7:0] wMask(input logic [7:0] a);
    case (a)
      8'h00, 8'h08, 8'h14: return 8'hEE;
      8'h01, 8'h09, 8'h15: return 8'h24;
      8'h04: return 8'h10;
      8'h07: return 8'h1F;
      8'h11: return 8'hF0;
      8'h12: return 8'hC8;
      8'h5B, 8'h5C, 8'h62: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rstOf(input logic [7:0] a);
    case (a)
      8'h00, 8'h14: return 8'hEE;
      8'h01, 8'h15: return 8'h24;
      8'h04: return 8'h10;
      8'h07: return 8'h07;
      8'h11: return 8'h60;
      8'h12: return 8'h08;
      8'h5B: return 8'h60;
      8'h5C: return 8'hFA;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] ctrlAddr(input int k);
    case (k)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h04;  3: return 8'h07;
      4: return 8'h08;  5: return 8'h09;  6: return 8'h11;  7: return 8'h12;
      8: return 8'h14;  9: return 8'h15; 10: return 8'h5B; 11: return 8'h5C;
      default: return 8'h62;
    endcase
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] a, input bit l);
    case (a)
      8'h05: return 8'h0A;
      8'h06: return 8'h08;
      8'h26: return {7'd0, mPerm};
      8'h27: return {6'd0, mLoss, mSoft};
      8'h12: return mReg[a] | {7'd0, l};
      default: return mReg[a];
    endcase
  endfunction

  function automatic logic [7:0] expOutEn();
    logic [7:0] h, lo;
    h = mReg[8'h00]; lo = mReg[8'h01];
    return {h[1], h[2], h[3], h[5], h[6], h[7], lo[2], lo[5]};
  endfunction

  function automatic string reqFor(input logic [7:0] a);
    if (a == 8'h05 || a == 8'h06) return "R9";
    if (a == 8'h26) return "R4";
    if (a == 8'h27) return "R5";
    if (a == 8'h12) return "R8";
    if (wMask(a) != 8'h00) return "R2";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at falling edge, model the rising edge, check at next falling edge
  task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                     input logic [7:0] d, input bit l, input string tag);
    logic [7:0] exp;
    bit locked, clr;
    wrEn = w; rdEn = r; addr = a; wrData = d; lossN = l;
    exp = expRead(a, l);
    locked = mPerm | mSoft;
    clr = 1'b0;
    if (w) begin
      if (a == 8'h26) begin
        if (d[0]) mPerm = 1'b1;
      end else if (a == 8'h27) begin
        if (d[0]) mSoft = !mSoft;
        clr = d[1];
      end else if (!locked && wMask(a) != 8'h00) begin
        mReg[a] = d & wMask(a);
      end
    end
    mLoss = !l | (mLoss & !clr);
    @(negedge clk);
    if (r) begin
      check((tag == "") ? reqFor(a) : tag, rdData, exp);
      lastRd = exp;
    end else begin
      check("R3", rdData, lastRd);
    end
    check("R11", outEn, expOutEn());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; wrEn = 0; rdEn = 0; addr = 0; wrData = 0; lossN = 1'b1;
    for (int i = 0; i < 256; i++) mReg[i] = rstOf(8'(i));
    mPerm = 0; mSoft = 0; mLoss = 0; lastRd = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", rdData, 8'h00);
    check("R1", outEn, 8'hFF);
    check("R1", {6'd0, lossEvent, writeLocked}, 8'h00);

    // R1: reset values of every control byte
    for (int k = 0; k < 13; k++) cyc(0, 1, ctrlAddr(k), 8'h00, 1, "R1");

    // R2: full-ones and zero writes keep only writable bits
    for (int k = 0; k < 13; k++) begin
      cyc(1, 0, ctrlAddr(k), 8'hFF, 1, "");
      cyc(0, 1, ctrlAddr(k), 8'h00, 1, "R2");
    end
    cyc(1, 0, 8'h00, 8'h00, 1, "");
    cyc(0, 1, 8'h00, 8'h00, 1, "R11");
    cyc(1, 0, 8'h00, 8'hA4, 1, "");
    cyc(1, 0, 8'h01, 8'h20, 1, "");

    // R9, R10: read-only and unmapped offsets
    cyc(1, 0, 8'h05, 8'hFF, 1, "");
    cyc(0, 1, 8'h05, 8'h00, 1, "R9");
    cyc(1, 0, 8'h06, 8'h00, 1, "");
    cyc(0, 1, 8'h06, 8'h00, 1, "R9");
    cyc(1, 0, 8'h03, 8'hFF, 1, "");
    cyc(0, 1, 8'h03, 8'h00, 1, "R10");
    cyc(1, 0, 8'hFF, 8'hFF, 1, "");
    cyc(0, 1, 8'hFF, 8'h00, 1, "R10");

    // R3: read in the same cycle as a write returns the old value
    cyc(1, 1, 8'h11, 8'h30, 1, "R3");
    cyc(0, 1, 8'h11, 8'h00, 1, "R3");

    // R7, R8: sticky loss flag, set wins over clear
    cyc(0, 1, 8'h12, 8'h00, 0, "R8");
    cyc(1, 0, 8'h27, 8'h02, 0, "");
    cyc(0, 1, 8'h27, 8'h00, 1, "R7");
    cyc(0, 1, 8'h27, 8'h00, 1, "R7");
    cyc(1, 0, 8'h27, 8'h02, 1, "");
    cyc(0, 1, 8'h27, 8'h00, 1, "R7");

    // R5, R6: clearable lock blocks control writes, toggles back
    cyc(1, 0, 8'h27, 8'h01, 1, "");
    cyc(0, 1, 8'h27, 8'h00, 1, "R5");
    cyc(1, 0, 8'h07, 8'h1A, 1, "");
    cyc(0, 1, 8'h07, 8'h00, 1, "R6");
    cyc(1, 0, 8'h27, 8'h00, 1, "");
    cyc(0, 1, 8'h27, 8'h00, 1, "R5");
    cyc(1, 0, 8'h27, 8'h01, 1, "");
    cyc(1, 0, 8'h07, 8'h1A, 1, "");
    cyc(0, 1, 8'h07, 8'h00, 1, "R6");

    // random phase, permanent lock excluded
    for (int n = 0; n < 4000; n++) begin
      int k;
      logic [7:0] a;
      k = int'($urandom % 24);
      if (k < 13)       a = ctrlAddr(k);
      else if (k < 17)  a = 8'h27;
      else if (k == 17) a = 8'h05;
      else if (k == 18) a = 8'h06;
      else              a = 8'($urandom);
      if (a == 8'h26) a = 8'h27;
      cyc(bit'($urandom % 2), bit'($urandom % 2), a, 8'($urandom),
          ($urandom % 16) != 0, "");
    end

    // R4, R6: permanent lock
    if (mSoft) cyc(1, 0, 8'h27, 8'h01, 1, "");
    cyc(1, 0, 8'h26, 8'h01, 1, "");
    cyc(1, 0, 8'h26, 8'h00, 1, "");
    cyc(1, 0, 8'h26, 8'hFE, 1, "");
    cyc(0, 1, 8'h26, 8'h00, 1, "R4");
    cyc(1, 0, 8'h00, 8'h00, 1, "");
    cyc(0, 1, 8'h00, 8'h00, 1, "R6");
    cyc(1, 0, 8'h27, 8'h01, 0, "");
    cyc(1, 0, 8'h27, 8'h02, 1, "");
    cyc(0, 1, 8'h27, 8'h00, 1, "R6");
    check("R4", {7'd0, writeLocked}, 8'h01);
    cyc(0, 0, 8'h00, 8'h00, 1, "");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule